// File: doc/BRIEF.md
# Serial Multichannel DAC Register Interface

This block is the digital front end of a twelve-channel, eight-bit digital-to-analog converter, built as logic that runs on a system clock. A host sends 12-bit frames over three wires: a data line, a shift clock and a load strobe. The shift clock and the load strobe are treated as levels and are sampled on the system clock. Each rising edge of the shift clock moves one bit into a 12-bit shift register. Each rising edge of the load strobe decodes the frame. The frame carries an eight-bit value and a four-bit channel address. The value goes into the holding latch of the addressed channel, and channel addresses that match no channel do nothing.

The bit that leaves the far end of the shift register is driven on a serial output. Several devices can therefore be chained on one data line, sharing the shift clock and the load strobe. One load then updates every device in the chain from the frame it holds.

For each channel the block presents the stored code and a converter step count one above it. The step count runs from 1 to 256 in units of 1/256 of the reference span. The analog ladder, the amplifiers and the references are outside the block.

Top module: `serial_dac_frontend`

## Requirements
- R1: While reset is asserted, every channel code is 0, every step value is 1, the shift register holds zeros and the serial output is 0.
- R2: On a system clock edge where the shift clock is high and was low on the previous edge, the serial input moves into the shift register. The register does not shift on any other edge.
- R3: The serial output is the bit that entered the register 12 shift edges earlier, that is, the bit leaving the far end. When two devices are chained, the first 12 of 24 bits sent end up in the downstream device.
- R4: The first bit shifted in is frame bit D11 and the last is D0. The channel value is D7..D0, with D0 as its least significant bit.
- R5: The channel address is the 4-bit value {D8,D9,D10,D11}, with D8 as the most significant bit. Address values 1 to 12 select channels 1 to 12, which are exposed as channel index 0 to 11.
- R6: Address values 0, 13, 14 and 15 change no channel code. The frame still travels through the register to the serial output.
- R7: A write happens once, on a rising edge of the load strobe. Holding the load strobe high while frames are shifted leaves every channel code unchanged.
- R8: Each channel's 9-bit step value equals its code plus one, so code 0 gives 1 and code 255 gives 256.
- R9: A load changes at most one channel code, and every other channel keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial frame data |
| shift_clk | input | 1 | Shift clock level; its rising edge shifts one bit |
| load | input | 1 | Load strobe level; its rising edge writes the frame |
| ser_out | output | 1 | Far-end bit of the shift register, for chaining |
| chan_code | output | NUM_CH*DATA_W (96) | Holding-latch codes; channel k is at [k*DATA_W +: DATA_W] |
| chan_step | output | NUM_CH*(DATA_W+1) (108) | Step values; channel k is at [k*(DATA_W+1) +: DATA_W+1] |

## Verification
The bench builds two instances with the default parameters: DATA_W 8, SEL_W 4 and NUM_CH 12. Because SEL_W is 4 and NUM_CH is 12, the three unused high addresses and the zero address can all be reached. Because DATA_W is 8, both ends of the step range (1 and 256) are reachable. The two instances are chained, so the far-end bit and the 24-bit split between devices can be observed at the downstream device's ports. Random frames, random address values and loads held high across shifting then cover the other corners.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
   parameter int DEF_DATA_W = 8;
   parameter int DEF_SEL_W  = 4;
   parameter int DEF_NUM_CH = 12;

   // address 0 is reserved as a no-op, so the field reaches 2**w - 1 channels
   function automatic int max_channels(input int sel_w);
      return (1 << sel_w) - 1;
   endfunction
endpackage

// File: rtl/dac_fe_edge.sv
module dac_fe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
   parameter int FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   output logic [FRAME_W-1:0] frame,
   output logic               dout
);
   // newest bit enters at index 0, oldest sits at FRAME_W-1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame <= '0;
      else if (shift_en) frame <= {frame[FRAME_W-2:0], din};
   end

   assign dout = frame[FRAME_W-1];
endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode #(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 4,
   parameter int NUM_CH  = 12,
   localparam int FRAME_W = DATA_W + SEL_W
) (
   input  logic [FRAME_W-1:0] frame,
   input  logic               load_stb,
   output logic [NUM_CH-1:0]  wr_en,
   output logic [DATA_W-1:0]  wr_data
);
   logic [SEL_W-1:0] sel_code;

   // lowest address bit in the frame is the most significant select bit
   always_comb begin
      for (int i = 0; i < SEL_W; i++) begin
         sel_code[SEL_W-1-i] = frame[DATA_W+i];
      end
   end

   assign wr_data = frame[DATA_W-1:0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
      assign wr_en[ch] = load_stb && (sel_code == SEL_W'(ch + 1));
   end
endmodule

// File: rtl/dac_fe_latch.sv
module dac_fe_latch #(
   parameter int DATA_W = 8,
   localparam int STEP_W = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] code,
   output logic [STEP_W-1:0] step
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code <= '0;
      else if (wr) code <= din;
   end

   assign step = {1'b0, code} + STEP_W'(1);
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
   import dac_fe_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int SEL_W  = DEF_SEL_W,
   parameter int NUM_CH = DEF_NUM_CH
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ser_in,
   input  logic                           shift_clk,
   input  logic                           load,
   output logic                           ser_out,
   output logic [NUM_CH*DATA_W-1:0]       chan_code,
   output logic [NUM_CH*(DATA_W+1)-1:0]   chan_step
);
   localparam int FRAME_W = DATA_W + SEL_W;
   localparam int STEP_W  = DATA_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("serial_dac_frontend: DATA_W must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel_w
      $error("serial_dac_frontend: SEL_W must be 1 to 8");
   end
   if (NUM_CH < 1 || NUM_CH > max_channels(SEL_W)) begin : g_bad_num_ch
      $error("serial_dac_frontend: NUM_CH does not fit the select field");
   end

   logic               sh_rise;
   logic               ld_rise;
   logic [FRAME_W-1:0] frame_q;
   logic [NUM_CH-1:0]  wr_en;
   logic [DATA_W-1:0]  wr_data;

   dac_fe_edge u_sh_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (shift_clk),
      .rise (sh_rise)
   );

   dac_fe_edge u_ld_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (load),
      .rise (ld_rise)
   );

   dac_fe_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sh_rise),
      .din     (ser_in),
      .frame   (frame_q),
      .dout    (ser_out)
   );

   dac_fe_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_dec (
      .frame   (frame_q),
      .load_stb(ld_rise),
      .wr_en   (wr_en),
      .wr_data (wr_data)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      dac_fe_latch #(.DATA_W(DATA_W)) u_latch (
         .clk  (clk),
         .rst_n(rst_n),
         .wr   (wr_en[ch]),
         .din  (wr_data),
         .code (chan_code[ch*DATA_W +: DATA_W]),
         .step (chan_step[ch*STEP_W +: STEP_W])
      );
   end
endmodule

// File: rtl/serial_dac_frontend_chk.sv
module serial_dac_frontend_chk #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4,
   parameter int NUM_CH = 12,
   localparam int FRAME_W = DATA_W + SEL_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sh_pulse,
   input logic                     ld_pulse,
   input logic [FRAME_W-1:0]       frame,
   input logic                     ser_out,
   input logic [NUM_CH*DATA_W-1:0] chan_code
);
   int unsigned                sel_val;
   logic                       sel_valid;
   logic [NUM_CH*DATA_W-1:0]   code_prev_q;
   logic [NUM_CH-1:0]          chg;

   always_comb begin
      sel_val = 0;
      for (int i = 0; i < SEL_W; i++) begin
         sel_val = (sel_val << 1) | 32'(frame[DATA_W+i]);
      end
      sel_valid = (sel_val != 0) && (sel_val <= NUM_CH);
   end

   always_ff @(posedge clk) code_prev_q <= chan_code;

   always_comb begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
         chg[ch] = chan_code[ch*DATA_W +: DATA_W] != code_prev_q[ch*DATA_W +: DATA_W];
      end
   end

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (chan_code == '0 && frame == '0 && ser_out == 1'b0);
      end
   end

   a_r2_no_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_pulse |=> $stable(frame) && $stable(ser_out));

   a_r3_far_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
      sh_pulse |=> ser_out == $past(frame[FRAME_W-2]));

   a_r6_bad_sel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pulse && !sel_valid) |=> $stable(chan_code));

   a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_pulse |=> $stable(chan_code));

   a_r9_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1);
endmodule

bind serial_dac_frontend serial_dac_frontend_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sh_pulse (sh_rise),
   .ld_pulse (ld_rise),
   .frame    (frame_q),
   .ser_out  (ser_out),
   .chan_code(chan_code)
);

// File: tb/test_serial_dac_frontend.sv
module test_serial_dac_frontend;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int SW  = 4;
   localparam int NCH = 12;
   localparam int FW  = DW + SW;
   localparam int STW = DW + 1;

   logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, sclk = 1'b0, ld = 1'b0;
   logic so_a, so_b;
   logic [NCH*DW-1:0]  code_a, code_b;
   logic [NCH*STW-1:0] step_a, step_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_dac_frontend i_serial_dac_frontend (
      .clk(clk), .rst_n(rst_n), .ser_in(din), .shift_clk(sclk), .load(ld),
      .ser_out(so_a), .chan_code(code_a), .chan_step(step_a));

   serial_dac_frontend i_serial_dac_frontend_dn (
      .clk(clk), .rst_n(rst_n), .ser_in(so_a), .shift_clk(sclk), .load(ld),
      .ser_out(so_b), .chan_code(code_b), .chan_step(step_b));

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference: a 24-bit chain queue, index 0 newest
   bit chain[$];
   int mcode[2][NCH];
   bit sclk_m, ld_m;
   int snap[NCH];

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int dev_code(int dev, int ch);
      return dev == 0 ? int'(code_a[ch*DW +: DW]) : int'(code_b[ch*DW +: DW]);
   endfunction

   function automatic int dev_step(int dev, int ch);
      return dev == 0 ? int'(step_a[ch*STW +: STW]) : int'(step_b[ch*STW +: STW]);
   endfunction

   task automatic model_load();
      for (int d = 0; d < 2; d++) begin
         int data = 0;
         int sel  = 0;
         for (int i = 0; i < DW; i++) data += int'(chain[d*FW + i]) << i;
         for (int i = DW; i < FW; i++) sel = (sel << 1) | int'(chain[d*FW + i]);
         if (sel >= 1 && sel <= NCH) mcode[d][sel-1] = data;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         chain.delete();
         for (int i = 0; i < 2*FW; i++) chain.push_back(1'b0);
         for (int d = 0; d < 2; d++)
            for (int c = 0; c < NCH; c++) mcode[d][c] = 0;
         sclk_m = 1'b0;
         ld_m   = 1'b0;
      end else begin
         if (ld && !ld_m) model_load();
         if (sclk && !sclk_m) begin
            chain.push_front(din);
            void'(chain.pop_back());
         end
         sclk_m = sclk;
         ld_m   = ld;
      end
   end

   // per-clock comparison against the reference (R2 R3 R4 R5 R8 R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int d = 0; d < 2; d++) begin
            bit ok_c = 1, ok_s = 1;
            int bad_c = 0;
            for (int c = 0; c < NCH; c++) begin
               if (dev_code(d, c) != mcode[d][c]) begin ok_c = 0; bad_c = c; end
               if (dev_step(d, c) != mcode[d][c] + 1) ok_s = 0;
            end
            check(ok_c, "R5", $sformatf("dev%0d channel %0d code", d, bad_c),
                  dev_code(d, bad_c), mcode[d][bad_c]);
            check(ok_s, "R8", $sformatf("dev%0d step", d), dev_step(d, bad_c), mcode[d][bad_c] + 1);
         end
         check(so_a == chain[FW-1], "R3", "upstream serial out", int'(so_a), int'(chain[FW-1]));
         check(so_b == chain[2*FW-1], "R3", "downstream serial out", int'(so_b), int'(chain[2*FW-1]));
      end
   end

   task automatic shift_frame(int sel, int data);
      for (int i = FW-1; i >= 0; i--) begin
         @(negedge clk);
         din  = (i >= DW) ? sel[FW-1-i] : data[i];
         sclk = 1'b1;
         @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic pulse_load();
      @(negedge clk) ld = 1'b1;
      @(negedge clk) ld = 1'b0;
      @(negedge clk);
   endtask

   task automatic take_snap();
      for (int c = 0; c < NCH; c++) snap[c] = dev_code(0, c);
   endtask

   task automatic check_snap(string req, string what);
      for (int c = 0; c < NCH; c++)
         check(dev_code(0, c) == snap[c], req, $sformatf("%s ch%0d", what, c), dev_code(0, c), snap[c]);
   endtask

   task automatic report();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
         report();
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         check(dev_code(0, c) == 0, "R1", "reset code", dev_code(0, c), 0);
         check(dev_step(0, c) == 1, "R1", "reset step", dev_step(0, c), 1);
      end
      check(so_a == 1'b0, "R1", "reset serial out", int'(so_a), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 each address reaches its own channel
      for (int ch = 1; ch <= NCH; ch++) begin
         int val = (ch * 37 + 5) & 8'hFF;
         shift_frame(ch, val);
         pulse_load();
         check(dev_code(0, ch-1) == val, "R4", $sformatf("write ch%0d", ch), dev_code(0, ch-1), val);
      end

      // R6 ignored address values
      for (int k = 0; k < 4; k++) begin
         int sel = (k == 0) ? 0 : 12 + k;
         take_snap();
         shift_frame(sel, 8'hA5);
         pulse_load();
         check_snap("R6", $sformatf("ignored sel %0d", sel));
      end

      // R8 step end points
      shift_frame(1, 0);
      pulse_load();
      check(dev_step(0, 0) == 1, "R8", "step at code 0", dev_step(0, 0), 1);
      shift_frame(12, 255);
      pulse_load();
      check(dev_step(0, 11) == 256, "R8", "step at code 255", dev_step(0, 11), 256);

      // R7 load held high across shifting
      shift_frame(15, 8'h11);
      @(negedge clk) ld = 1'b1;
      @(negedge clk);
      take_snap();
      shift_frame(3, 8'h3C);
      repeat (2) @(negedge clk);
      check_snap("R7", "load held high");
      ld = 1'b0;
      pulse_load();
      check(dev_code(0, 2) == 8'h3C, "R7", "write after new edge", dev_code(0, 2), 8'h3C);

      // R3 two-device split of a 24-bit stream
      shift_frame(7, 8'h81);
      shift_frame(2, 8'h42);
      pulse_load();
      check(dev_code(1, 6) == 8'h81, "R3", "downstream gets first frame", dev_code(1, 6), 8'h81);
      check(dev_code(0, 1) == 8'h42, "R3", "upstream gets second frame", dev_code(0, 1), 8'h42);

      // R9 random frames, single loads and chained loads
      for (int n = 0; n < 150; n++) begin
         int sel  = int'($urandom_range(0, 15));
         int data = int'($urandom_range(0, 255));
         shift_frame(sel, data);
         if (n % 3 != 0) begin
            pulse_load();
            if (sel >= 1 && sel <= NCH)
               check(dev_code(0, sel-1) == data, "R9", "random write", dev_code(0, sel-1), data);
         end
      end

      report();
   end
endmodule